// File: doc/BRIEF.md
# Timer Interrupt Mask, Status and Clear Unit

This block holds the interrupt registers of a two-channel timer. Channels A and B each deliver one-cycle event pulses for time-out, capture match, capture event and compare match. Two shared sources add an RTC event and a write-update-error event. Every pulse is latched into a raw status register, whatever the mask says. A mask register decides which latched bits reach the interrupt controller. A masked status view shows raw status ANDed with the mask.

Software acknowledges a source by writing ones to a write-one-to-clear register. That single write drops the bit from both the raw and the masked view. Each channel drives one level-sensitive request line. Channel A's line also carries the RTC source, and channel B's line also carries the write-update-error source. A small register port reads and writes the four registers. Reads are combinational and writes take effect at the next clock edge.

Top module: `tmr_irq_ctrl`

## Requirements
- R1: The register port selects a register with `reg_addr`: 0 is the mask, 1 is the raw status, 2 is the masked status and 3 is the clear register. Source bits are: 0 A time-out, 1 A capture match, 2 A capture event, 3 RTC, 4 A match, 8 B time-out, 9 B capture match, 10 B capture event, 11 B match, 16 write-update error. All other bits read as zero, even after ones are written to them.
- R2: A mask bit of 1 enables its source and 0 disables it. A written mask value is read back from the next cycle on.
- R3: An event pulse sets its raw status bit at the next clock edge, whether or not the source is masked.
- R4: The masked status register reads as raw status AND mask, with the same bit layout.
- R5: `irq_a` is the OR of masked bits 0 to 4. `irq_b` is the OR of masked bits 8 to 11 and 16. Both are level outputs taken from registered state.
- R6: Writing 1 to a bit of the clear register clears that bit in both raw and masked status at the next edge. Writing 0 leaves the bit unchanged.
- R7: A raw status bit that is never cleared stays set across any number of cycles.
- R8: When an event pulse and a clear write hit the same bit in the same cycle, the bit stays set.
- R9: The clear register reads as zero. Writes to the raw and masked status addresses have no effect.
- R10: While `rst_n` is low at a clock edge, mask and raw status become zero, so both request lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_a | input | 4 | Channel A pulses: [0] time-out, [1] capture match, [2] capture event, [3] match |
| evt_b | input | 4 | Channel B pulses, same order as `evt_a` |
| evt_rtc | input | 1 | RTC event pulse |
| evt_wue | input | 1 | Write-update-error event pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Combinational read data for `reg_addr` |
| irq_a | output | 1 | Channel A interrupt request (level) |
| irq_b | output | 1 | Channel B interrupt request (level) |

## Verification
Every bit of raw status and mask can be read directly at the port. A wrong latch, a lost clear or a stuck reserved bit therefore shows at address 1 or 0 on the first read after the edge that caused it. A fault in the AND or in the request grouping shows the same cycle on address 2 or on `irq_a`/`irq_b`, for any raw bit set while its mask bit is 1. The random stimulus overlaps events, clears and mask writes so that priority and grouping faults get caught. Directed cases cover reserved bits and the collision between an event and a clear on the same bit.

// File: rtl/tmr_irq_pkg.sv
// Shared constants for the timer interrupt unit: register selects, source
// bit positions and the derived group masks.
// Assumes REG_W of at least 17 so the highest source bit fits.
package tmr_irq_pkg;

    localparam int REG_W   = 32;
    localparam int ADDR_W  = 2;
    localparam int CH_EVT  = 4;

    // Bit position of each per-channel source, index = evt_a/evt_b bit
    localparam int A_POS [CH_EVT] = '{0, 1, 2, 4};
    localparam int B_POS [CH_EVT] = '{8, 9, 10, 11};
    localparam int RTC_POS = 3;
    localparam int WUE_POS = 16;

    typedef enum logic [ADDR_W-1:0] {
        SEL_MASK  = 2'd0,
        SEL_RAW   = 2'd1,
        SEL_MSTAT = 2'd2,
        SEL_CLEAR = 2'd3
    } reg_sel_e;

    // Bits that feed the channel A request line
    function automatic logic [REG_W-1:0] grp_a_bits();
        logic [REG_W-1:0] v;
        v = '0;
        for (int i = 0; i < CH_EVT; i++) v[A_POS[i]] = 1'b1;
        v[RTC_POS] = 1'b1;
        return v;
    endfunction

    // Bits that feed the channel B request line
    function automatic logic [REG_W-1:0] grp_b_bits();
        logic [REG_W-1:0] v;
        v = '0;
        for (int i = 0; i < CH_EVT; i++) v[B_POS[i]] = 1'b1;
        v[WUE_POS] = 1'b1;
        return v;
    endfunction

    localparam logic [REG_W-1:0] GRP_A = grp_a_bits();
    localparam logic [REG_W-1:0] GRP_B = grp_b_bits();
    localparam logic [REG_W-1:0] VALID = GRP_A | GRP_B;

endpackage

// File: rtl/tmr_irq_evmap.sv
// Event mapper: places the per-channel and shared event pulses onto their
// status bit positions. Purely combinational.
// Assumes one-cycle pulses from the timer counters.
module tmr_irq_evmap
    import tmr_irq_pkg::*;
(
    input  logic [CH_EVT-1:0] evt_a,
    input  logic [CH_EVT-1:0] evt_b,
    input  logic              evt_rtc,
    input  logic              evt_wue,
    output logic [REG_W-1:0]  evt_vec
);

    // Scatter each pulse onto its bit; reserved bits stay zero
    always_comb begin
        evt_vec = '0;
        for (int i = 0; i < CH_EVT; i++) begin
            evt_vec[A_POS[i]] = evt_a[i];
            evt_vec[B_POS[i]] = evt_b[i];
        end
        evt_vec[RTC_POS] = evt_rtc;
        evt_vec[WUE_POS] = evt_wue;
    end

endmodule

// File: rtl/tmr_irq_status.sv
// Status bank: one mask flop and one raw status flop for each implemented
// bit. Reserved bits have no flops and read as zero. An event beats a
// clear on the same bit.
// Assumes the write strobes are already decoded from the register port.
module tmr_irq_status #(
    parameter int               REG_W = 32,
    parameter logic [REG_W-1:0] VALID = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] evt_vec,
    input  logic             mask_we,
    input  logic             clr_we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] mask_q,
    output logic [REG_W-1:0] raw_q
);

    logic [REG_W-1:0] clr_bits;

    // Bits that a clear write hits this cycle
    assign clr_bits = clr_we ? wdata : '0;

    for (genvar b = 0; b < REG_W; b++) begin : g_bit
        if (VALID[b]) begin : g_live
            logic m_r;
            logic r_r;
            // Mask bit: loaded by a mask write
            always_ff @(posedge clk) begin
                if (!rst_n)       m_r <= 1'b0;
                else if (mask_we) m_r <= wdata[b];
            end
            // Raw bit: set by an event, dropped by a clear; the event wins
            always_ff @(posedge clk) begin
                if (!rst_n) r_r <= 1'b0;
                else        r_r <= evt_vec[b] | (r_r & ~clr_bits[b]);
            end
            assign mask_q[b] = m_r;
            assign raw_q[b]  = r_r;
        end else begin : g_rsvd
            assign mask_q[b] = 1'b0;
            assign raw_q[b]  = 1'b0;
        end
    end

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> mask_q == ($past(wdata) & VALID)); // R2

    AST_RAW_CATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_vec & VALID)) |=> ((raw_q & $past(evt_vec & VALID)) == $past(evt_vec & VALID))); // R3

    AST_CLR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((raw_q & $past(clr_bits & ~evt_vec)) == '0)); // R6

    AST_RAW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (|raw_q) |=> ((($past(raw_q) & ~$past(clr_bits)) & ~raw_q) == '0)); // R7

    AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_bits & evt_vec & VALID)) |=> ((raw_q & $past(clr_bits & evt_vec & VALID)) != '0)); // R8

endmodule

// File: rtl/tmr_irq_reqgen.sv
// Request generator: reduces the masked status onto the two level request
// lines using the group masks given as parameters.
// Assumes the masked status input is built from registers, so no glitches.
module tmr_irq_reqgen #(
    parameter int               REG_W = 32,
    parameter logic [REG_W-1:0] GRP_A = '0,
    parameter logic [REG_W-1:0] GRP_B = '0
) (
    input  logic [REG_W-1:0] masked,
    output logic             irq_a,
    output logic             irq_b
);

    // OR-reduce each channel's group of masked bits
    always_comb begin
        irq_a = |(masked & GRP_A);
        irq_b = |(masked & GRP_B);
    end

endmodule

// File: rtl/tmr_irq_ctrl.sv
// Timer interrupt unit top: decodes the register port, holds mask and raw
// status, forms the masked view and drives one request line per channel.
// Assumes a single-cycle write strobe; reads are combinational.
module tmr_irq_ctrl
    import tmr_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CH_EVT-1:0] evt_a,
    input  logic [CH_EVT-1:0] evt_b,
    input  logic              evt_rtc,
    input  logic              evt_wue,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq_a,
    output logic              irq_b
);

    logic [REG_W-1:0] evt_vec;
    logic [REG_W-1:0] mask_q;
    logic [REG_W-1:0] raw_q;
    logic [REG_W-1:0] masked;
    logic             mask_we;
    logic             clr_we;
    reg_sel_e         sel;

    // Register select and write strobes
    always_comb begin
        sel     = reg_sel_e'(reg_addr);
        mask_we = reg_wr && (sel == SEL_MASK);
        clr_we  = reg_wr && (sel == SEL_CLEAR);
    end

    tmr_irq_evmap u_evmap (
        .evt_a   (evt_a),
        .evt_b   (evt_b),
        .evt_rtc (evt_rtc),
        .evt_wue (evt_wue),
        .evt_vec (evt_vec)
    );

    tmr_irq_status #(
        .REG_W (REG_W),
        .VALID (VALID)
    ) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_vec (evt_vec),
        .mask_we (mask_we),
        .clr_we  (clr_we),
        .wdata   (reg_wdata),
        .mask_q  (mask_q),
        .raw_q   (raw_q)
    );

    // Masked view: only enabled sources survive
    assign masked = raw_q & mask_q;

    tmr_irq_reqgen #(
        .REG_W (REG_W),
        .GRP_A (GRP_A),
        .GRP_B (GRP_B)
    ) u_reqgen (
        .masked (masked),
        .irq_a  (irq_a),
        .irq_b  (irq_b)
    );

    // Read multiplexer; the clear register has no storage and reads zero
    always_comb begin
        unique case (sel)
            SEL_MASK:  reg_rdata = mask_q;
            SEL_RAW:   reg_rdata = raw_q;
            SEL_MSTAT: reg_rdata = masked;
            default:   reg_rdata = '0;
        endcase
    end

    AST_NO_MASK_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> (!irq_a && !irq_b)); // R2

    AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd3) |-> (reg_rdata == '0)); // R9

    AST_RAW_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd1 && (evt_vec == '0)) |=> (raw_q == $past(raw_q))); // R9

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!irq_a && !irq_b && raw_q == '0 && mask_q == '0)); // R10

endmodule

// File: tb/tb_tmr_irq_ctrl.sv
module tb_tmr_irq_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] V_ALL = 32'h0001_0F1F;
    localparam logic [31:0] G_A   = 32'h0000_001F;
    localparam logic [31:0] G_B   = 32'h0001_0F00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  evt_a = '0, evt_b = '0;
    logic        evt_rtc = 1'b0, evt_wue = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_a, irq_b;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [31:0] m_mask = '0;
    logic [31:0] m_raw  = '0;

    tmr_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .evt_a(evt_a), .evt_b(evt_b),
        .evt_rtc(evt_rtc), .evt_wue(evt_wue), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_a(irq_a), .irq_b(irq_b)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Source positions as stated in R1
    function automatic logic [31:0] ev_bits(input logic [3:0] a, input logic [3:0] b,
                                            input logic rtc, input logic wue);
        logic [31:0] v;
        v = '0;
        v[0] = a[0]; v[1] = a[1]; v[2] = a[2]; v[4] = a[3];
        v[3] = rtc;
        for (int i = 0; i < 4; i++) v[8+i] = b[i];
        v[16] = wue;
        return v;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        reg_addr = 2'd0; #1 chk({tag, " mask"},   reg_rdata, m_mask);
        reg_addr = 2'd1; #1 chk({tag, " raw"},    reg_rdata, m_raw);
        reg_addr = 2'd2; #1 chk({tag, " masked"}, reg_rdata, m_raw & m_mask);
        reg_addr = 2'd3; #1 chk({tag, " clear-read"}, reg_rdata, 32'h0);
        chk({tag, " irq_a"}, {31'h0, irq_a}, {31'h0, |(m_raw & m_mask & G_A)});
        chk({tag, " irq_b"}, {31'h0, irq_b}, {31'h0, |(m_raw & m_mask & G_B)});
    endtask

    // One clock: drive, update the model at the edge, release at negedge
    task automatic step(input logic [3:0] a, input logic [3:0] b, input logic rtc,
                        input logic wue, input logic we, input logic [1:0] adr,
                        input logic [31:0] wd);
        logic [31:0] clr;
        evt_a = a; evt_b = b; evt_rtc = rtc; evt_wue = wue;
        reg_wr = we; reg_addr = adr; reg_wdata = wd;
        @(posedge clk);
        clr = (we && adr == 2'd3) ? wd : 32'h0;
        m_raw = (m_raw & ~clr) | ev_bits(a, b, rtc, wue);
        if (we && adr == 2'd0) m_mask = wd & V_ALL;
        @(negedge clk);
        evt_a = '0; evt_b = '0; evt_rtc = 1'b0; evt_wue = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        check_all("R10 reset");
        rst_n = 1'b1;

        // R1: reserved mask bits read zero
        step(4'h0, 4'h0, 0, 0, 1, 2'd0, 32'hFFFF_FFFF);
        check_all("R1 reserved");
        step(4'h0, 4'h0, 0, 0, 1, 2'd0, 32'h0);

        // R3: masked-off events still latch, no request
        step(4'hF, 4'hF, 1, 1, 0, 2'd0, 32'h0);
        check_all("R3 latch unmasked");

        // R6: clear of zero is a no-op, then clear channel B bits
        step(4'h0, 4'h0, 0, 0, 1, 2'd3, 32'h0);
        check_all("R6 zero clear");
        step(4'h0, 4'h0, 0, 0, 1, 2'd3, 32'h0000_0F00);
        check_all("R6 clear B");

        // R9: writes to status addresses ignored
        step(4'h0, 4'h0, 0, 0, 1, 2'd1, 32'h0000_0000);
        step(4'h0, 4'h0, 0, 0, 1, 2'd2, 32'hFFFF_FFFF);
        check_all("R9 status write ignored");

        // R7: bits hold while idle
        repeat (5) step(4'h0, 4'h0, 0, 0, 0, 2'd0, 32'h0);
        check_all("R7 hold");

        // R8: event beats clear on the same bit
        step(4'h0, 4'h0, 0, 0, 1, 2'd3, 32'hFFFF_FFFF);
        check_all("R6 clear all");
        step(4'h1, 4'h0, 0, 0, 1, 2'd3, 32'h0000_0001);
        check_all("R8 event wins");

        // R5: grouping of shared sources onto request lines
        step(4'h0, 4'h0, 0, 0, 1, 2'd3, 32'hFFFF_FFFF);
        step(4'h0, 4'h0, 0, 0, 1, 2'd0, 32'h0001_0000);
        step(4'h0, 4'h0, 0, 1, 0, 2'd0, 32'h0);
        check_all("R5 wue to irq_b");
        step(4'h0, 4'h0, 1, 0, 1, 2'd0, 32'h0000_0008);
        check_all("R5 rtc to irq_a");

        // R2/R4: mask written over pending bits gates output
        step(4'h0, 4'h0, 0, 0, 1, 2'd0, 32'h0000_0000);
        check_all("R2 mask off");

        // R4: random mix of events, clears and mask writes
        for (int k = 0; k < 400; k++) begin
            logic [3:0] ra, rb;
            logic [1:0] radr;
            ra = 4'($urandom) & 4'($urandom);
            rb = 4'($urandom) & 4'($urandom);
            radr = 2'($urandom);
            step(ra, rb, ($urandom % 5) == 0, ($urandom % 5) == 0,
                 ($urandom % 3) == 0, radr, $urandom);
            check_all("R4 random");
        end

        // R10: reset in mid-run clears everything
        rst_n = 1'b0;
        @(posedge clk);
        m_raw = '0; m_mask = '0;
        @(negedge clk);
        check_all("R10 mid-run reset");

        finish_run();
    end

endmodule